// File: doc/BRIEF.md
# Platform system control register bank

This block is a small bank of byte-wide ports on an 8-bit I/O bus. A host drives an address, a write or read strobe and write data. The bank decodes one reset/endian port and a group of control and status ports. Writes to the control ports change the outputs that the rest of the platform uses: a hard-reset request, a hardfile activity light, a 4-bit system control field and an I/O map mode bit. Writes to two password-protect ports raise a one-cycle toggle pulse on one of two NVRAM lock channels.

Reads return either stored state or fixed identification codes. Read data appears on the bus one clock after the read strobe and holds until the next read. Ports that are not decoded read as all ones and ignore writes. Every port address is a module parameter, so the same bank can sit at any place in the I/O map.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the outputs are as follows: hreset_req, hardfile_led, nv_lock1, nv_lock2 and map_sparse are 0, sys_ctrl is 0 and io_rdata is 0x00. The internal endian flag is also 0.
- R2: A write to the reset port takes effect one cycle after the strobe. Bit 0 of the data drives hreset_req (1 asserts it, 0 clears it) and bit 1 stores the endian flag.
- R3: A read of the reset port returns the endian flag in bit 1 and zero in every other bit.
- R4: The identification ports are read-only. They return 0xEF (CPU configuration), 0xAD (base feature), 0xE0 (base status), 0x39 (extended feature) and 0x03 (cache status, no L2 present). Writes to them change no output and no read value.
- R5: A write to the light port sets hardfile_led to bit 0 of the data, one cycle after the strobe.
- R6: Each write to lock port 1 or lock port 2 raises nv_lock1 or nv_lock2 for exactly the one cycle after the strobe, whatever the data. The other channel stays low.
- R7: A write to the system control port stores data bits 3:0 in sys_ctrl. A read of that port returns 0 in bits 7:4 and the stored field in bits 3:0.
- R8: A write to the map type port stores data bit 0 in map_sparse. A read of that port returns that bit in bit 0 and zero in bits 7:1.
- R9: A read of an undecoded address returns 0xFF, and so does a read of a write-only port (light, lock 1, lock 2). A write to an undecoded address changes no output, raises no pulse and changes no read value.
- R10: io_rdata is loaded only on the clock edge where io_rd is high. It is valid from that edge on and holds its value while io_rd is low. A read in the same cycle as a write returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| hreset_req | output | 1 | Hard-reset request |
| hardfile_led | output | 1 | Hardfile activity light |
| nv_lock1 | output | 1 | NVRAM lock channel 1 toggle pulse |
| nv_lock2 | output | 1 | NVRAM lock channel 2 toggle pulse |
| sys_ctrl | output | CTL_W | System control field |
| map_sparse | output | 1 | I/O map mode bit |

## Verification
The bench builds the bank with a 16-bit address and the default port map of eleven scattered addresses. It passes these addresses to the instance explicitly, so its expectation model does not depend on the RTL defaults. Decoding compares the full address, so random undecoded addresses across the whole 16-bit space check that near-miss addresses stay unmapped. Random writes with all-ones and all-zeros data check the field masking of the system control, map, reset and light ports. They also check that the lock pulses ignore the data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int NPORT     = 11;
  localparam int IX_RST    = 0;
  localparam int IX_CPUCFG = 1;
  localparam int IX_FEAT   = 2;
  localparam int IX_STAT   = 3;
  localparam int IX_EXTF   = 4;
  localparam int IX_CACHE  = 5;
  localparam int IX_LIGHT  = 6;
  localparam int IX_LOCK1  = 7;
  localparam int IX_LOCK2  = 8;
  localparam int IX_SYSCTL = 9;
  localparam int IX_MAP    = 10;

  localparam logic [7:0] ID_CPUCFG   = 8'hEF;
  localparam logic [7:0] ID_FEAT     = 8'hAD;
  localparam logic [7:0] ID_STAT     = 8'hE0;
  localparam logic [7:0] ID_EXTF     = 8'h39;
  localparam logic [7:0] ID_CACHE    = 8'h03;
  localparam logic [7:0] RD_UNMAPPED = 8'hFF;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int ADDR_W = 16,
  parameter int NPORT  = 11,
  parameter logic [NPORT*ADDR_W-1:0] PORT_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NPORT-1:0]  hit
);
  for (genvar i = 0; i < NPORT; i++) begin : g_cmp
    assign hit[i] = (addr == PORT_MAP[i*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [NPORT-1:0] hit,
  input  logic [7:0]       wdata,
  output logic             hreset,
  output logic             endian,
  output logic             light,
  output logic             lock1,
  output logic             lock2,
  output logic [CTL_W-1:0] ctl,
  output logic             map_mode
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      hreset   <= 1'b0;
      endian   <= 1'b0;
      light    <= 1'b0;
      lock1    <= 1'b0;
      lock2    <= 1'b0;
      ctl      <= '0;
      map_mode <= 1'b0;
    end else begin
      lock1 <= wr & hit[IX_LOCK1];
      lock2 <= wr & hit[IX_LOCK2];
      if (wr && hit[IX_RST]) begin
        hreset <= wdata[0];
        endian <= wdata[1];
      end
      if (wr && hit[IX_LIGHT])  light    <= wdata[0];
      if (wr && hit[IX_SYSCTL]) ctl      <= wdata[CTL_W-1:0];
      if (wr && hit[IX_MAP])    map_mode <= wdata[0];
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [NPORT-1:0] hit,
  input  logic             endian,
  input  logic [CTL_W-1:0] ctl,
  input  logic             map_mode,
  output logic [7:0]       rdata
);
  logic [7:0] val [NPORT];
  logic [7:0] rd_next;

  assign val[IX_RST]    = {6'b0, endian, 1'b0};
  assign val[IX_CPUCFG] = ID_CPUCFG;
  assign val[IX_FEAT]   = ID_FEAT;
  assign val[IX_STAT]   = ID_STAT;
  assign val[IX_EXTF]   = ID_EXTF;
  assign val[IX_CACHE]  = ID_CACHE;
  assign val[IX_LIGHT]  = RD_UNMAPPED;
  assign val[IX_LOCK1]  = RD_UNMAPPED;
  assign val[IX_LOCK2]  = RD_UNMAPPED;
  assign val[IX_SYSCTL] = {{(8-CTL_W){1'b0}}, ctl};
  assign val[IX_MAP]    = {7'b0, map_mode};

  always_comb begin
    rd_next = RD_UNMAPPED;
    for (int i = 0; i < NPORT; i++) begin
      if (hit[i]) rd_next = val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 8'h00;
    else if (rd) rdata <= rd_next;
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CTL_W  = 4,
  parameter logic [ADDR_W-1:0] P_RST    = 16'h0092,
  parameter logic [ADDR_W-1:0] P_CPUCFG = 16'h0800,
  parameter logic [ADDR_W-1:0] P_FEAT   = 16'h0802,
  parameter logic [ADDR_W-1:0] P_STAT   = 16'h0803,
  parameter logic [ADDR_W-1:0] P_EXTF   = 16'h080C,
  parameter logic [ADDR_W-1:0] P_CACHE  = 16'h081C,
  parameter logic [ADDR_W-1:0] P_LIGHT  = 16'h0808,
  parameter logic [ADDR_W-1:0] P_LOCK1  = 16'h0810,
  parameter logic [ADDR_W-1:0] P_LOCK2  = 16'h0812,
  parameter logic [ADDR_W-1:0] P_SYSCTL = 16'h0814,
  parameter logic [ADDR_W-1:0] P_MAP    = 16'h0850
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              hreset_req,
  output logic              hardfile_led,
  output logic              nv_lock1,
  output logic              nv_lock2,
  output logic [CTL_W-1:0]  sys_ctrl,
  output logic              map_sparse
);
  localparam logic [NPORT*ADDR_W-1:0] PORT_MAP =
    {P_MAP, P_SYSCTL, P_LOCK2, P_LOCK1, P_LIGHT, P_CACHE,
     P_EXTF, P_STAT, P_FEAT, P_CPUCFG, P_RST};

  logic [NPORT-1:0] port_hit;
  logic             endian_flag;

  sysctl_decode #(.ADDR_W(ADDR_W), .NPORT(NPORT), .PORT_MAP(PORT_MAP)) i_decode (
    .addr (io_addr),
    .hit  (port_hit)
  );

  sysctl_regs #(.CTL_W(CTL_W)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (io_wr),
    .hit      (port_hit),
    .wdata    (io_wdata),
    .hreset   (hreset_req),
    .endian   (endian_flag),
    .light    (hardfile_led),
    .lock1    (nv_lock1),
    .lock2    (nv_lock2),
    .ctl      (sys_ctrl),
    .map_mode (map_sparse)
  );

  sysctl_rdmux #(.CTL_W(CTL_W)) i_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (io_rd),
    .hit      (port_hit),
    .endian   (endian_flag),
    .ctl      (sys_ctrl),
    .map_mode (map_sparse),
    .rdata    (io_rdata)
  );
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int CTL_W  = 4,
  parameter logic [ADDR_W-1:0] P_RST    = '0,
  parameter logic [ADDR_W-1:0] P_CPUCFG = '0,
  parameter logic [ADDR_W-1:0] P_LIGHT  = '0,
  parameter logic [ADDR_W-1:0] P_LOCK1  = '0,
  parameter logic [ADDR_W-1:0] P_LOCK2  = '0,
  parameter logic [ADDR_W-1:0] P_SYSCTL = '0,
  parameter logic [ADDR_W-1:0] P_MAP    = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              hreset_req,
  input logic              hardfile_led,
  input logic              nv_lock1,
  input logic              nv_lock2,
  input logic [CTL_W-1:0]  sys_ctrl,
  input logic              map_sparse
);
  a_r2_reset_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(io_wr && io_addr == P_RST)) |-> (hreset_req == $past(io_wdata[0])));

  a_r4_cpucfg_code: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(io_rd && io_addr == P_CPUCFG)) |-> (io_rdata == 8'hEF));

  a_r5_led_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(io_wr && io_addr == P_LIGHT)) |-> (hardfile_led == $past(io_wdata[0])));

  a_r6_lock1_pulse: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (nv_lock1 == $past(io_wr && io_addr == P_LOCK1)));

  a_r6_lock2_pulse: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (nv_lock2 == $past(io_wr && io_addr == P_LOCK2)));

  a_r7_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(io_wr && io_addr == P_SYSCTL)) |-> $stable(sys_ctrl));

  a_r8_map_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(io_wr && io_addr == P_MAP)) |-> $stable(map_sparse));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(io_rd)) |-> $stable(io_rdata));
endmodule

bind sysctl_bank sysctl_bank_chk #(
  .ADDR_W(ADDR_W), .CTL_W(CTL_W), .P_RST(P_RST), .P_CPUCFG(P_CPUCFG),
  .P_LIGHT(P_LIGHT), .P_LOCK1(P_LOCK1), .P_LOCK2(P_LOCK2),
  .P_SYSCTL(P_SYSCTL), .P_MAP(P_MAP)
) i_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .hreset_req(hreset_req),
  .hardfile_led(hardfile_led), .nv_lock1(nv_lock1), .nv_lock2(nv_lock2),
  .sys_ctrl(sys_ctrl), .map_sparse(map_sparse)
);

// File: tb/test_sysctl_bank.sv
`timescale 1ns/1ps
module test_sysctl_bank;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_RST    = 16'h0092;
  localparam logic [AW-1:0] A_CPUCFG = 16'h0800;
  localparam logic [AW-1:0] A_FEAT   = 16'h0802;
  localparam logic [AW-1:0] A_STAT   = 16'h0803;
  localparam logic [AW-1:0] A_EXTF   = 16'h080C;
  localparam logic [AW-1:0] A_CACHE  = 16'h081C;
  localparam logic [AW-1:0] A_LIGHT  = 16'h0808;
  localparam logic [AW-1:0] A_LOCK1  = 16'h0810;
  localparam logic [AW-1:0] A_LOCK2  = 16'h0812;
  localparam logic [AW-1:0] A_SYSCTL = 16'h0814;
  localparam logic [AW-1:0] A_MAP    = 16'h0850;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic hreset_req, hardfile_led, nv_lock1, nv_lock2, map_sparse;
  logic [3:0] sys_ctrl;

  always #2.5 clk = ~clk;

  sysctl_bank #(
    .ADDR_W(AW), .CTL_W(4), .P_RST(A_RST), .P_CPUCFG(A_CPUCFG), .P_FEAT(A_FEAT),
    .P_STAT(A_STAT), .P_EXTF(A_EXTF), .P_CACHE(A_CACHE), .P_LIGHT(A_LIGHT),
    .P_LOCK1(A_LOCK1), .P_LOCK2(A_LOCK2), .P_SYSCTL(A_SYSCTL), .P_MAP(A_MAP)
  ) i_sysctl_bank (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .hreset_req(hreset_req),
    .hardfile_led(hardfile_led), .nv_lock1(nv_lock1), .nv_lock2(nv_lock2),
    .sys_ctrl(sys_ctrl), .map_sparse(map_sparse)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_hreset = 0, m_endian = 0, m_light = 0, m_map = 0;
  logic [3:0] m_ctl = 0;
  logic [7:0] last_rd = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  function automatic bit decoded(input logic [AW-1:0] a);
    return a == A_RST || a == A_CPUCFG || a == A_FEAT || a == A_STAT ||
           a == A_EXTF || a == A_CACHE || a == A_LIGHT || a == A_LOCK1 ||
           a == A_LOCK2 || a == A_SYSCTL || a == A_MAP;
  endfunction

  function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
    case (a)
      A_RST:    return {6'b0, m_endian, 1'b0};
      A_CPUCFG: return 8'hEF;
      A_FEAT:   return 8'hAD;
      A_STAT:   return 8'hE0;
      A_EXTF:   return 8'h39;
      A_CACHE:  return 8'h03;
      A_SYSCTL: return {4'b0, m_ctl};
      A_MAP:    return {7'b0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic string req_of(input logic [AW-1:0] a);
    case (a)
      A_RST:                             return "R2";
      A_CPUCFG, A_FEAT, A_STAT,
      A_EXTF, A_CACHE:                   return "R4";
      A_LIGHT:                           return "R5";
      A_LOCK1, A_LOCK2:                  return "R6";
      A_SYSCTL:                          return "R7";
      A_MAP:                             return "R8";
      default:                           return "R9";
    endcase
  endfunction

  task automatic check_outs(input string req, input bit l1, input bit l2);
    chk({req, " hreset_req"}, {7'b0, hreset_req}, {7'b0, m_hreset});
    chk({req, " hardfile_led"}, {7'b0, hardfile_led}, {7'b0, m_light});
    chk({req, " sys_ctrl"}, {4'b0, sys_ctrl}, {4'b0, m_ctl});
    chk({req, " map_sparse"}, {7'b0, map_sparse}, {7'b0, m_map});
    chk({req, " nv_lock1"}, {7'b0, nv_lock1}, {7'b0, l1});
    chk({req, " nv_lock2"}, {7'b0, nv_lock2}, {7'b0, l2});
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    case (a)
      A_RST:    begin m_hreset = d[0]; m_endian = d[1]; end
      A_LIGHT:  m_light = d[0];
      A_SYSCTL: m_ctl = d[3:0];
      A_MAP:    m_map = d[0];
      default:  ;
    endcase
    check_outs(req_of(a), a == A_LOCK1, a == A_LOCK2);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk(req, io_rdata, e);
    last_rd = e;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] a;
    logic [7:0] d;
    logic [AW-1:0] ports [11];
    ports = '{A_RST, A_CPUCFG, A_FEAT, A_STAT, A_EXTF, A_CACHE,
              A_LIGHT, A_LOCK1, A_LOCK2, A_SYSCTL, A_MAP};
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_outs("R1", 1'b0, 1'b0);
    chk("R1 io_rdata", io_rdata, 8'h00);
    do_read(A_RST, "R1 endian flag");

    // R2 / R3 reset port
    do_write(A_RST, 8'h01);
    do_write(A_RST, 8'hFC);
    do_write(A_RST, 8'h03);
    do_read(A_RST, "R3 endian readback set");
    do_write(A_RST, 8'h00);
    do_read(A_RST, "R3 endian readback clear");

    // R4 identification codes, writes ignored
    do_read(A_CPUCFG, "R4 cpu cfg");
    do_read(A_FEAT, "R4 feature");
    do_read(A_STAT, "R4 status");
    do_read(A_EXTF, "R4 ext feature");
    do_read(A_CACHE, "R4 cache status");
    do_write(A_CPUCFG, 8'h00);
    do_write(A_CACHE, 8'hFF);
    do_read(A_CPUCFG, "R4 cpu cfg after write");
    do_read(A_CACHE, "R4 cache after write");

    // R5 light
    do_write(A_LIGHT, 8'hFF);
    do_write(A_LIGHT, 8'hFE);
    do_write(A_LIGHT, 8'h01);

    // R6 lock pulses, one cycle, data ignored
    do_write(A_LOCK1, 8'h00);
    @(negedge clk);
    chk("R6 lock1 one cycle", {7'b0, nv_lock1}, 8'h00);
    do_write(A_LOCK2, 8'hFF);
    @(negedge clk);
    chk("R6 lock2 one cycle", {7'b0, nv_lock2}, 8'h00);

    // R7 system control masking
    do_write(A_SYSCTL, 8'hFA);
    do_read(A_SYSCTL, "R7 ctl readback");
    do_write(A_SYSCTL, 8'h05);
    do_read(A_SYSCTL, "R7 ctl readback 2");

    // R8 map bit
    do_write(A_MAP, 8'hFF);
    do_read(A_MAP, "R8 map readback set");
    do_write(A_MAP, 8'hFE);
    do_read(A_MAP, "R8 map readback clear");

    // R9 undecoded and write-only reads
    do_read(16'h0093, "R9 undecoded read");
    do_read(A_LIGHT, "R9 write-only light read");
    do_read(A_LOCK1, "R9 write-only lock read");
    do_write(16'h0815, 8'hFF);
    do_read(A_SYSCTL, "R9 undecoded write left ctl");

    // R10 hold while idle and read-during-write
    do_read(A_CPUCFG, "R10 read");
    repeat (3) @(negedge clk);
    chk("R10 hold", io_rdata, 8'hEF);
    @(negedge clk);
    io_addr = A_SYSCTL; io_wdata = 8'h0C; io_wr = 1'b1; io_rd = 1'b1;
    d = {4'b0, m_ctl};
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    m_ctl = 4'hC;
    chk("R10 read old value during write", io_rdata, d);
    chk("R7 write during read", {4'b0, sys_ctrl}, 8'h0C);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom % 14;
      d = 8'($urandom);
      if (sel < 11) a = ports[sel];
      else begin
        a = AW'($urandom);
        while (decoded(a)) a = AW'($urandom);
      end
      if ($urandom % 2) do_write(a, d);
      else do_read(a, {req_of(a), " random read"});
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        chk("R10 random hold", io_rdata, last_rd);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule